// File: doc/BRIEF.md
# AXI4-Lite 64-to-32 Bit Lite Downsizer

This block joins a 64-bit AXI4-Lite requester to a 32-bit AXI4-Lite completer. Every wide write or read is turned into one or two narrow transactions. The choice depends on address bit 2 and, for writes, on which half of the byte strobe carries any enable.

For writes, the block picks the data lane that goes out. Upper-word accesses are sent to the address with bit 2 forced high. For reads, it places the returned words into the proper halves of the 64-bit read data.

When a wide access needs two narrow ones, the two narrow responses are combined into one response for the requester. Each direction holds a single transaction at a time. Writes and reads go through independent paths.

Top module: `axil_dn_bridge`

## Requirements
- R1: During and right after reset these outputs are low: `s_b_valid_o`, `s_r_valid_o`, `m_aw_valid_o`, `m_w_valid_o` and `m_ar_valid_o`. In the same state `s_ar_ready_o` is high, and `s_aw_ready_o` is low while no write is offered.
- R2: A write is sent as two narrow writes when address bit 2 is 0 and both strobe halves are non-zero (strobe bits [3:0] non-zero and bits [7:4] non-zero). The first narrow write uses the given address, data[31:0] and strobe[3:0]. The second uses the address with bit 2 set, data[63:32] and strobe[7:4].
- R3: A write is sent as one narrow write when address bit 2 is 0 and strobe[7:4] is zero. It uses the given address, data[31:0] and strobe[3:0]. This includes the case where the whole strobe is zero.
- R4: A write is sent as one narrow write to the address with bit 2 set when address bit 2 is 1, or when strobe[3:0] is zero and strobe[7:4] is not. It uses data[63:32] and strobe[7:4].
- R5: A read with address bit 2 equal to 0 is sent as two narrow reads, first at the address and then at the address with bit 2 set. The first returned word fills read data [31:0] and the second fills [63:32]. No wide response is presented before the second word has arrived.
- R6: A read with address bit 2 equal to 1 is sent as one narrow read at the given address. The returned word appears in read data [63:32].
- R7: Response codes are OKAY=0, EXOKAY=1, SLVERR=2 and DECERR=3. For a split access the wide response is the numerically larger of the two narrow codes. For a single access the narrow code is passed through unchanged.
- R8: A write is accepted only when address and data are offered together, and both ready outputs rise in the same cycle. After accepting a write or a read, the block keeps that direction's ready outputs low until its wide response has been accepted.
- R9: A narrow valid keeps its payload unchanged until the matching ready. A wide response keeps its valid, code and data until the matching ready.
- R10: The protection bits of the wide address are copied unchanged to every narrow address it produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_aw_addr_i | input | ADDR_W | Wide write address |
| s_aw_prot_i | input | 3 | Wide write protection |
| s_aw_valid_i | input | 1 | Wide write address valid |
| s_aw_ready_o | output | 1 | Wide write address ready |
| s_w_data_i | input | 64 | Wide write data |
| s_w_strb_i | input | 8 | Wide write byte strobe |
| s_w_valid_i | input | 1 | Wide write data valid |
| s_w_ready_o | output | 1 | Wide write data ready |
| s_b_resp_o | output | 2 | Merged write response code |
| s_b_valid_o | output | 1 | Write response valid |
| s_b_ready_i | input | 1 | Write response ready |
| s_ar_addr_i | input | ADDR_W | Wide read address |
| s_ar_prot_i | input | 3 | Wide read protection |
| s_ar_valid_i | input | 1 | Wide read address valid |
| s_ar_ready_o | output | 1 | Wide read address ready |
| s_r_data_o | output | 64 | Assembled read data |
| s_r_resp_o | output | 2 | Merged read response code |
| s_r_valid_o | output | 1 | Read data valid |
| s_r_ready_i | input | 1 | Read data ready |
| m_aw_addr_o | output | ADDR_W | Narrow write address |
| m_aw_prot_o | output | 3 | Narrow write protection |
| m_aw_valid_o | output | 1 | Narrow write address valid |
| m_aw_ready_i | input | 1 | Narrow write address ready |
| m_w_data_o | output | 32 | Narrow write data |
| m_w_strb_o | output | 4 | Narrow write strobe |
| m_w_valid_o | output | 1 | Narrow write data valid |
| m_w_ready_i | input | 1 | Narrow write data ready |
| m_b_resp_i | input | 2 | Narrow write response code |
| m_b_valid_i | input | 1 | Narrow write response valid |
| m_b_ready_o | output | 1 | Narrow write response ready |
| m_ar_addr_o | output | ADDR_W | Narrow read address |
| m_ar_prot_o | output | 3 | Narrow read protection |
| m_ar_valid_o | output | 1 | Narrow read address valid |
| m_ar_ready_i | input | 1 | Narrow read address ready |
| m_r_data_i | input | 32 | Narrow read data |
| m_r_resp_i | input | 2 | Narrow read response code |
| m_r_valid_i | input | 1 | Narrow read data valid |
| m_r_ready_o | output | 1 | Narrow read data ready |

## Verification
A wrong lane or split decision becomes visible on the narrow address and data channels within one cycle of acceptance: the wrong address, the wrong data half or a wrong beat count. A stuck "second beat pending" flag shows up quite differently, as a third narrow request or as a wide response that never arrives. The bench catches that through its beat counts and its bounded waits.

A corrupted response accumulator or read-data register shows only on the wide response, several cycles after the narrow beats have finished. For that reason every access compares the merged code and both data halves against values computed from the rules. Ready outputs that wrongly stay high while a response is pending are exposed by offering a new request while a response is held back.

// File: rtl/axil_dn_pkg.sv
package axil_dn_pkg;
  localparam int WIDE_W      = 64;
  localparam int NARROW_W    = 32;
  localparam int WIDE_STRB   = WIDE_W / 8;
  localparam int NARROW_STRB = NARROW_W / 8;
  localparam int HI_BIT      = $clog2(NARROW_STRB);

  typedef logic [1:0] resp_t;
  localparam resp_t RESP_OKAY = 2'd0;

  typedef enum logic [1:0] {XS_IDLE, XS_BUS, XS_RESP} xfer_state_e;

  // larger code wins: DECERR > SLVERR > EXOKAY > OKAY
  function automatic resp_t worse_resp(resp_t a, resp_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/axil_dn_wr.sv
module axil_dn_wr
  import axil_dn_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      s_aw_addr_i,
  input  logic [2:0]             s_aw_prot_i,
  input  logic                   s_aw_valid_i,
  output logic                   s_aw_ready_o,
  input  logic [WIDE_W-1:0]      s_w_data_i,
  input  logic [WIDE_STRB-1:0]   s_w_strb_i,
  input  logic                   s_w_valid_i,
  output logic                   s_w_ready_o,
  output resp_t                  s_b_resp_o,
  output logic                   s_b_valid_o,
  input  logic                   s_b_ready_i,
  output logic [ADDR_W-1:0]      m_aw_addr_o,
  output logic [2:0]             m_aw_prot_o,
  output logic                   m_aw_valid_o,
  input  logic                   m_aw_ready_i,
  output logic [NARROW_W-1:0]    m_w_data_o,
  output logic [NARROW_STRB-1:0] m_w_strb_o,
  output logic                   m_w_valid_o,
  input  logic                   m_w_ready_i,
  input  resp_t                  m_b_resp_i,
  input  logic                   m_b_valid_i,
  output logic                   m_b_ready_o
);
  localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(1) << HI_BIT;

  xfer_state_e          state_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [2:0]           prot_q;
  logic [WIDE_W-1:0]    data_q;
  logic [WIDE_STRB-1:0] strb_q;
  logic                 aw_pend_q, w_pend_q, cur_hi_q, more_q;
  resp_t                resp_q;

  logic accept, lo_any, hi_any, split, start_hi;

  assign accept   = (state_q == XS_IDLE) && s_aw_valid_i && s_w_valid_i;
  assign lo_any   = |s_w_strb_i[NARROW_STRB-1:0];
  assign hi_any   = |s_w_strb_i[WIDE_STRB-1:NARROW_STRB];
  assign split    = !s_aw_addr_i[HI_BIT] && lo_any && hi_any;
  assign start_hi = s_aw_addr_i[HI_BIT] || (hi_any && !lo_any);

  assign s_aw_ready_o = accept;
  assign s_w_ready_o  = accept;
  assign s_b_valid_o  = (state_q == XS_RESP);
  assign s_b_resp_o   = resp_q;

  assign m_aw_addr_o  = cur_hi_q ? (addr_q | HI_OFS) : addr_q;
  assign m_aw_prot_o  = prot_q;
  assign m_aw_valid_o = (state_q == XS_BUS) && aw_pend_q;
  assign m_w_data_o   = cur_hi_q ? data_q[WIDE_W-1:NARROW_W] : data_q[NARROW_W-1:0];
  assign m_w_strb_o   = cur_hi_q ? strb_q[WIDE_STRB-1:NARROW_STRB] : strb_q[NARROW_STRB-1:0];
  assign m_w_valid_o  = (state_q == XS_BUS) && w_pend_q;
  assign m_b_ready_o  = (state_q == XS_BUS) && !aw_pend_q && !w_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= XS_IDLE;
      addr_q    <= '0;
      prot_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
      cur_hi_q  <= 1'b0;
      more_q    <= 1'b0;
      resp_q    <= RESP_OKAY;
    end else begin
      unique case (state_q)
        XS_IDLE: if (accept) begin
          addr_q    <= s_aw_addr_i;
          prot_q    <= s_aw_prot_i;
          data_q    <= s_w_data_i;
          strb_q    <= s_w_strb_i;
          aw_pend_q <= 1'b1;
          w_pend_q  <= 1'b1;
          cur_hi_q  <= start_hi;
          more_q    <= split;
          resp_q    <= RESP_OKAY;
          state_q   <= XS_BUS;
        end
        XS_BUS: begin
          if (m_aw_valid_o && m_aw_ready_i) aw_pend_q <= 1'b0;
          if (m_w_valid_o && m_w_ready_i)   w_pend_q  <= 1'b0;
          if (m_b_valid_i && m_b_ready_o) begin
            resp_q <= worse_resp(resp_q, m_b_resp_i);
            if (more_q) begin
              more_q    <= 1'b0;
              cur_hi_q  <= 1'b1;
              aw_pend_q <= 1'b1;
              w_pend_q  <= 1'b1;
            end else begin
              state_q <= XS_RESP;
            end
          end
        end
        XS_RESP: if (s_b_ready_i) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axil_dn_rd.sv
module axil_dn_rd
  import axil_dn_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   s_ar_addr_i,
  input  logic [2:0]          s_ar_prot_i,
  input  logic                s_ar_valid_i,
  output logic                s_ar_ready_o,
  output logic [WIDE_W-1:0]   s_r_data_o,
  output resp_t               s_r_resp_o,
  output logic                s_r_valid_o,
  input  logic                s_r_ready_i,
  output logic [ADDR_W-1:0]   m_ar_addr_o,
  output logic [2:0]          m_ar_prot_o,
  output logic                m_ar_valid_o,
  input  logic                m_ar_ready_i,
  input  logic [NARROW_W-1:0] m_r_data_i,
  input  resp_t               m_r_resp_i,
  input  logic                m_r_valid_i,
  output logic                m_r_ready_o
);
  localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(1) << HI_BIT;

  xfer_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        prot_q;
  logic [WIDE_W-1:0] data_q;
  logic              ar_pend_q, cur_hi_q, more_q;
  resp_t             resp_q;

  assign s_ar_ready_o = (state_q == XS_IDLE);
  assign s_r_valid_o  = (state_q == XS_RESP);
  assign s_r_data_o   = data_q;
  assign s_r_resp_o   = resp_q;

  assign m_ar_addr_o  = cur_hi_q ? (addr_q | HI_OFS) : addr_q;
  assign m_ar_prot_o  = prot_q;
  assign m_ar_valid_o = (state_q == XS_BUS) && ar_pend_q;
  assign m_r_ready_o  = (state_q == XS_BUS) && !ar_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= XS_IDLE;
      addr_q    <= '0;
      prot_q    <= '0;
      data_q    <= '0;
      ar_pend_q <= 1'b0;
      cur_hi_q  <= 1'b0;
      more_q    <= 1'b0;
      resp_q    <= RESP_OKAY;
    end else begin
      unique case (state_q)
        XS_IDLE: if (s_ar_valid_i) begin
          addr_q    <= s_ar_addr_i;
          prot_q    <= s_ar_prot_i;
          ar_pend_q <= 1'b1;
          cur_hi_q  <= s_ar_addr_i[HI_BIT];
          more_q    <= !s_ar_addr_i[HI_BIT];
          resp_q    <= RESP_OKAY;
          state_q   <= XS_BUS;
        end
        XS_BUS: begin
          if (m_ar_valid_o && m_ar_ready_i) ar_pend_q <= 1'b0;
          if (m_r_valid_i && m_r_ready_o) begin
            resp_q <= worse_resp(resp_q, m_r_resp_i);
            if (cur_hi_q) data_q[WIDE_W-1:NARROW_W] <= m_r_data_i;
            else          data_q[NARROW_W-1:0]      <= m_r_data_i;
            if (more_q) begin
              more_q    <= 1'b0;
              cur_hi_q  <= 1'b1;
              ar_pend_q <= 1'b1;
            end else begin
              state_q <= XS_RESP;
            end
          end
        end
        XS_RESP: if (s_r_ready_i) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axil_dn_bridge.sv
module axil_dn_bridge
  import axil_dn_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      s_aw_addr_i,
  input  logic [2:0]             s_aw_prot_i,
  input  logic                   s_aw_valid_i,
  output logic                   s_aw_ready_o,
  input  logic [WIDE_W-1:0]      s_w_data_i,
  input  logic [WIDE_STRB-1:0]   s_w_strb_i,
  input  logic                   s_w_valid_i,
  output logic                   s_w_ready_o,
  output logic [1:0]             s_b_resp_o,
  output logic                   s_b_valid_o,
  input  logic                   s_b_ready_i,
  input  logic [ADDR_W-1:0]      s_ar_addr_i,
  input  logic [2:0]             s_ar_prot_i,
  input  logic                   s_ar_valid_i,
  output logic                   s_ar_ready_o,
  output logic [WIDE_W-1:0]      s_r_data_o,
  output logic [1:0]             s_r_resp_o,
  output logic                   s_r_valid_o,
  input  logic                   s_r_ready_i,
  output logic [ADDR_W-1:0]      m_aw_addr_o,
  output logic [2:0]             m_aw_prot_o,
  output logic                   m_aw_valid_o,
  input  logic                   m_aw_ready_i,
  output logic [NARROW_W-1:0]    m_w_data_o,
  output logic [NARROW_STRB-1:0] m_w_strb_o,
  output logic                   m_w_valid_o,
  input  logic                   m_w_ready_i,
  input  logic [1:0]             m_b_resp_i,
  input  logic                   m_b_valid_i,
  output logic                   m_b_ready_o,
  output logic [ADDR_W-1:0]      m_ar_addr_o,
  output logic [2:0]             m_ar_prot_o,
  output logic                   m_ar_valid_o,
  input  logic                   m_ar_ready_i,
  input  logic [NARROW_W-1:0]    m_r_data_i,
  input  logic [1:0]             m_r_resp_i,
  input  logic                   m_r_valid_i,
  output logic                   m_r_ready_o
);
  axil_dn_wr #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni,
    .s_aw_addr_i, .s_aw_prot_i, .s_aw_valid_i, .s_aw_ready_o,
    .s_w_data_i, .s_w_strb_i, .s_w_valid_i, .s_w_ready_o,
    .s_b_resp_o, .s_b_valid_o, .s_b_ready_i,
    .m_aw_addr_o, .m_aw_prot_o, .m_aw_valid_o, .m_aw_ready_i,
    .m_w_data_o, .m_w_strb_o, .m_w_valid_o, .m_w_ready_i,
    .m_b_resp_i, .m_b_valid_i, .m_b_ready_o
  );

  axil_dn_rd #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni,
    .s_ar_addr_i, .s_ar_prot_i, .s_ar_valid_i, .s_ar_ready_o,
    .s_r_data_o, .s_r_resp_o, .s_r_valid_o, .s_r_ready_i,
    .m_ar_addr_o, .m_ar_prot_o, .m_ar_valid_o, .m_ar_ready_i,
    .m_r_data_i, .m_r_resp_i, .m_r_valid_i, .m_r_ready_o
  );
endmodule

// File: rtl/axil_dn_bridge_chk.sv
module axil_dn_bridge_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_aw_valid_i,
  input logic              s_aw_ready_o,
  input logic              s_w_ready_o,
  input logic              s_ar_valid_i,
  input logic              s_ar_ready_o,
  input logic [1:0]        s_b_resp_o,
  input logic              s_b_valid_o,
  input logic              s_b_ready_i,
  input logic [63:0]       s_r_data_o,
  input logic              s_r_valid_o,
  input logic              s_r_ready_i,
  input logic [ADDR_W-1:0] m_aw_addr_o,
  input logic              m_aw_valid_o,
  input logic              m_aw_ready_i,
  input logic [31:0]       m_w_data_o,
  input logic              m_w_valid_o,
  input logic              m_w_ready_i,
  input logic [ADDR_W-1:0] m_ar_addr_o,
  input logic              m_ar_valid_o,
  input logic              m_ar_ready_i
);
  // R8
  wr_aw_w_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_aw_ready_o |-> (s_w_ready_o && s_aw_valid_i));
  // R8
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_aw_ready_o |=> !s_aw_ready_o);
  // R8
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ar_valid_i && s_ar_ready_o) |=> !s_ar_ready_o);
  // R9
  m_aw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_aw_valid_o && !m_aw_ready_i) |=> (m_aw_valid_o && $stable(m_aw_addr_o)));
  // R9
  m_w_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_w_valid_o && !m_w_ready_i) |=> (m_w_valid_o && $stable(m_w_data_o)));
  // R9
  m_ar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_ar_valid_o && !m_ar_ready_i) |=> (m_ar_valid_o && $stable(m_ar_addr_o)));
  // R9
  s_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_b_valid_o && !s_b_ready_i) |=> (s_b_valid_o && $stable(s_b_resp_o)));
  // R9
  s_r_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_r_valid_o && !s_r_ready_i) |=> (s_r_valid_o && $stable(s_r_data_o)));
endmodule

bind axil_dn_bridge axil_dn_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .s_aw_valid_i(s_aw_valid_i), .s_aw_ready_o(s_aw_ready_o), .s_w_ready_o(s_w_ready_o),
  .s_ar_valid_i(s_ar_valid_i), .s_ar_ready_o(s_ar_ready_o),
  .s_b_resp_o(s_b_resp_o), .s_b_valid_o(s_b_valid_o), .s_b_ready_i(s_b_ready_i),
  .s_r_data_o(s_r_data_o), .s_r_valid_o(s_r_valid_o), .s_r_ready_i(s_r_ready_i),
  .m_aw_addr_o(m_aw_addr_o), .m_aw_valid_o(m_aw_valid_o), .m_aw_ready_i(m_aw_ready_i),
  .m_w_data_o(m_w_data_o), .m_w_valid_o(m_w_valid_o), .m_w_ready_i(m_w_ready_i),
  .m_ar_addr_o(m_ar_addr_o), .m_ar_valid_o(m_ar_valid_o), .m_ar_ready_i(m_ar_ready_i)
);

// File: tb/axil_dn_bridge_tb_top.sv
`timescale 1ns/1ps
module axil_dn_bridge_tb_top;
  localparam int AW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic [AW-1:0] s_aw_addr_i = '0;
  logic [2:0]    s_aw_prot_i = '0;
  logic          s_aw_valid_i = 1'b0, s_aw_ready_o;
  logic [63:0]   s_w_data_i = '0;
  logic [7:0]    s_w_strb_i = '0;
  logic          s_w_valid_i = 1'b0, s_w_ready_o;
  logic [1:0]    s_b_resp_o;
  logic          s_b_valid_o, s_b_ready_i = 1'b1;
  logic [AW-1:0] s_ar_addr_i = '0;
  logic [2:0]    s_ar_prot_i = '0;
  logic          s_ar_valid_i = 1'b0, s_ar_ready_o;
  logic [63:0]   s_r_data_o;
  logic [1:0]    s_r_resp_o;
  logic          s_r_valid_o, s_r_ready_i = 1'b1;
  logic [AW-1:0] m_aw_addr_o;
  logic [2:0]    m_aw_prot_o;
  logic          m_aw_valid_o, m_aw_ready_i = 1'b0;
  logic [31:0]   m_w_data_o;
  logic [3:0]    m_w_strb_o;
  logic          m_w_valid_o, m_w_ready_i = 1'b0;
  logic [1:0]    m_b_resp_i = '0;
  logic          m_b_valid_i = 1'b0, m_b_ready_o;
  logic [AW-1:0] m_ar_addr_o;
  logic [2:0]    m_ar_prot_o;
  logic          m_ar_valid_o, m_ar_ready_i = 1'b0;
  logic [31:0]   m_r_data_i = '0;
  logic [1:0]    m_r_resp_i = '0;
  logic          m_r_valid_i = 1'b0, m_r_ready_o;

  axil_dn_bridge #(.ADDR_W(AW)) dut_i (.*);

  int n_run = 0, n_fail = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_fn(logic [31:0] a);
    return a ^ 32'h5EED_F00D;
  endfunction

  // narrow-side completer model; drives at negedge, logs handshakes due at next posedge
  logic [31:0] aw_log[4], w_log[4], ar_log[4];
  logic [3:0]  s_log[4];
  logic [2:0]  p_log[4];
  logic [1:0]  resp_pl[2];
  int naw = 0, nw = 0, nb = 0, nar = 0, nr = 0;
  bit stall = 0, r_hold = 0, b_fire = 0, r_fire = 0;
  logic [31:0] cyc = '0;

  always @(negedge clk_i) begin
    cyc = cyc + 1;
    m_aw_ready_i = !stall || cyc[0];
    m_w_ready_i  = !stall || cyc[1];
    m_ar_ready_i = !stall || cyc[0];
    if (b_fire) begin m_b_valid_i = 1'b0; nb++; end
    if (!m_b_valid_i && nb < ((naw < nw) ? naw : nw)) begin
      m_b_valid_i = 1'b1;
      m_b_resp_i  = resp_pl[nb % 2];
    end
    b_fire = m_b_valid_i && m_b_ready_o;
    if (r_fire) begin m_r_valid_i = 1'b0; nr++; end
    if (!m_r_valid_i && nr < nar && !(r_hold && nr >= 1)) begin
      m_r_valid_i = 1'b1;
      m_r_data_i  = rd_fn(ar_log[nr % 4]);
      m_r_resp_i  = resp_pl[nr % 2];
    end
    r_fire = m_r_valid_i && m_r_ready_o;
    if (m_aw_valid_o && m_aw_ready_i) begin
      aw_log[naw % 4] = m_aw_addr_o; p_log[naw % 4] = m_aw_prot_o; naw++;
    end
    if (m_w_valid_o && m_w_ready_i) begin
      w_log[nw % 4] = m_w_data_o; s_log[nw % 4] = m_w_strb_o; nw++;
    end
    if (m_ar_valid_o && m_ar_ready_i) begin
      ar_log[nar % 4] = m_ar_addr_o; nar++;
    end
  end

  task automatic clear_log();
    naw = 0; nw = 0; nb = 0; nar = 0; nr = 0;
  endtask

  task automatic wr_txn(logic [31:0] a, logic [63:0] d, logic [7:0] s, logic [2:0] p,
                        output logic [1:0] resp);
    bit got;
    @(posedge clk_i); #1;
    clear_log();
    s_aw_addr_i = a; s_aw_prot_i = p; s_w_data_i = d; s_w_strb_i = s;
    s_aw_valid_i = 1'b1; s_w_valid_i = 1'b1;
    got = 0;
    for (int k = 0; k < 100 && !got; k++) begin @(negedge clk_i); got = s_aw_ready_o; end
    if (!got) chk("R8", "write accept", 0, 1);
    @(posedge clk_i); #1;
    s_aw_valid_i = 1'b0; s_w_valid_i = 1'b0;
    got = 0;
    for (int k = 0; k < 200 && !got; k++) begin @(negedge clk_i); got = s_b_valid_o; end
    if (!got) chk("R8", "write response", 0, 1);
    resp = s_b_resp_o;
    @(posedge clk_i); #1;
  endtask

  task automatic rd_txn(logic [31:0] a, logic [2:0] p, output logic [63:0] d, output logic [1:0] resp);
    bit got;
    @(posedge clk_i); #1;
    clear_log();
    s_ar_addr_i = a; s_ar_prot_i = p; s_ar_valid_i = 1'b1;
    got = 0;
    for (int k = 0; k < 100 && !got; k++) begin @(negedge clk_i); got = s_ar_ready_o; end
    if (!got) chk("R8", "read accept", 0, 1);
    @(posedge clk_i); #1;
    s_ar_valid_i = 1'b0;
    got = 0;
    for (int k = 0; k < 200 && !got; k++) begin @(negedge clk_i); got = s_r_valid_o; end
    if (!got) chk("R5", "read response", 0, 1);
    d = s_r_data_o; resp = s_r_resp_o;
    @(posedge clk_i); #1;
  endtask

  // {write, addr[31:0], strb[7:0], resp beat0, resp beat1}
  localparam int NV = 12;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 32'h0000_1000, 8'hFF, 2'd0, 2'd0},
    {1'b1, 32'h0000_1008, 8'h0F, 2'd0, 2'd0},
    {1'b1, 32'h0000_1010, 8'hF0, 2'd2, 2'd0},
    {1'b1, 32'h0000_1014, 8'hFF, 2'd0, 2'd0},
    {1'b1, 32'h0000_1020, 8'h31, 2'd0, 2'd3},
    {1'b1, 32'h0000_1028, 8'h00, 2'd1, 2'd0},
    {1'b1, 32'h0000_1034, 8'h0F, 2'd0, 2'd0},
    {1'b1, 32'h0000_1040, 8'h81, 2'd2, 2'd0},
    {1'b0, 32'h0000_2000, 8'h00, 2'd0, 2'd0},
    {1'b0, 32'h0000_2004, 8'h00, 2'd3, 2'd0},
    {1'b0, 32'h0000_2010, 8'h00, 2'd0, 2'd2},
    {1'b0, 32'h0000_200C, 8'h00, 2'd0, 2'd0}
  };

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [1:0]  resp, er;
    logic [63:0] rd;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "s_b_valid in reset", s_b_valid_o, 0);
    chk("R1", "m_aw_valid in reset", m_aw_valid_o, 0);
    chk("R1", "m_ar_valid in reset", m_ar_valid_o, 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "s_r_valid after reset", s_r_valid_o, 0);
    chk("R1", "m_w_valid after reset", m_w_valid_o, 0);
    chk("R1", "s_ar_ready idle", s_ar_ready_o, 1);
    chk("R1", "s_aw_ready idle", s_aw_ready_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] a, ea[2], ed[2];
      logic [3:0]  es[2];
      logic [7:0]  s;
      logic [63:0] d;
      logic [2:0]  p;
      int en;
      string tag;
      a = VEC[i][43:12]; s = VEC[i][11:4];
      resp_pl[0] = VEC[i][3:2]; resp_pl[1] = VEC[i][1:0];
      stall = i[0];
      p = i[2:0];
      d = {32'hAA00_0000 + i, 32'h5500_0000 + i};
      if (VEC[i][44]) begin
        if (!a[2] && (|s[3:0]) && (|s[7:4])) begin
          en = 2; tag = "R2";
          ea[0] = a; ed[0] = d[31:0]; es[0] = s[3:0];
          ea[1] = a | 32'h4; ed[1] = d[63:32]; es[1] = s[7:4];
          er = (resp_pl[0] > resp_pl[1]) ? resp_pl[0] : resp_pl[1];
        end else if (!a[2] && s[7:4] == 4'h0) begin
          en = 1; tag = "R3";
          ea[0] = a; ed[0] = d[31:0]; es[0] = s[3:0]; er = resp_pl[0];
        end else begin
          en = 1; tag = "R4";
          ea[0] = a | 32'h4; ed[0] = d[63:32]; es[0] = s[7:4]; er = resp_pl[0];
        end
        wr_txn(a, d, s, p, resp);
        chk(tag, "aw beats", naw, en);
        chk(tag, "w beats", nw, en);
        for (int k = 0; k < en; k++) begin
          chk(tag, "narrow addr", aw_log[k], ea[k]);
          chk(tag, "narrow data", w_log[k], ed[k]);
          chk(tag, "narrow strb", s_log[k], es[k]);
          chk("R10", "narrow prot", p_log[k], p);
        end
        chk("R7", "write resp", resp, er);
      end else begin
        rd_txn(a, p, rd, resp);
        if (!a[2]) begin
          chk("R5", "ar beats", nar, 2);
          chk("R5", "first addr", ar_log[0], a);
          chk("R5", "second addr", ar_log[1], a | 32'h4);
          chk("R5", "assembled data", rd, {rd_fn(a | 32'h4), rd_fn(a)});
          er = (resp_pl[0] > resp_pl[1]) ? resp_pl[0] : resp_pl[1];
        end else begin
          chk("R6", "ar beats", nar, 1);
          chk("R6", "addr", ar_log[0], a);
          chk("R6", "upper data", rd[63:32], rd_fn(a));
          er = resp_pl[0];
        end
        chk("R7", "read resp", resp, er);
      end
    end
    stall = 0;
    resp_pl[0] = 2'd0; resp_pl[1] = 2'd0;

    // R8: address alone is not accepted
    @(posedge clk_i); #1;
    clear_log();
    s_aw_addr_i = 32'h3000; s_aw_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R8", "aw ready without w", s_aw_ready_o, 0);
    chk("R8", "no narrow aw without w", naw, 0);
    wr_txn(32'h3000, 64'h1111_2222_3333_4444, 8'h0F, 3'd0, resp);
    chk("R3", "late-w write data", w_log[0], 32'h3333_4444);

    // R8/R9: held response blocks new writes
    s_b_ready_i = 1'b0;
    @(posedge clk_i); #1;
    s_aw_addr_i = 32'h3100; s_w_strb_i = 8'hFF; s_aw_valid_i = 1'b1; s_w_valid_i = 1'b1;
    @(negedge clk_i);
    @(posedge clk_i); #1;
    s_aw_addr_i = 32'h3200;
    repeat (20) @(negedge clk_i);
    chk("R9", "b valid held", s_b_valid_o, 1);
    chk("R8", "aw ready while resp pending", s_aw_ready_o, 0);
    chk("R8", "w ready while resp pending", s_w_ready_o, 0);
    @(posedge clk_i); #1;
    s_aw_valid_i = 1'b0; s_w_valid_i = 1'b0; s_b_ready_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R8", "b released", s_b_valid_o, 0);

    // R5: no wide read response with only the first word back
    r_hold = 1;
    @(posedge clk_i); #1;
    clear_log();
    s_ar_addr_i = 32'h4000; s_ar_valid_i = 1'b1;
    @(negedge clk_i);
    @(posedge clk_i); #1 s_ar_valid_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R5", "first word only back", nr, 1);
    chk("R5", "r valid early", s_r_valid_o, 0);
    r_hold = 0;
    for (int k = 0; k < 50 && !s_r_valid_o; k++) @(negedge clk_i);
    chk("R5", "held read data", s_r_data_o, {rd_fn(32'h4004), rd_fn(32'h4000)});
    repeat (2) @(posedge clk_i);

    finish_run();
  end
endmodule